// File: doc/BRIEF.md
# Serial Converter Frame and Power-Mode Controller

This block is the digital side of a single-channel sampling converter that reports its results over a three-wire serial link. An external host pulls an active-low select line low to start a conversion frame. It then toggles a serial clock, and the block places one result bit on the serial data line for each falling edge of that clock. The conversion word itself comes from a parallel input port. The block adds leading zeros and any trailing padding to that word and sends it most significant bit first. While no frame is in progress it releases the data line, which is shown by a data-enable output.

The host also chooses the power mode through the point at which it raises the select line. A release early in a frame puts the converter into power-down. A release late in a frame abandons the conversion but keeps the converter powered. A frame that runs long enough while the converter is powered down wakes it, and the output of that waking frame is marked as not valid. After every frame the converter needs a quiet interval before the next start. A start request that arrives too early is dropped and recorded in a sticky error flag. Both the select line and the serial clock are asynchronous to the system clock and are brought into its domain through two-flop synchronisers.

Top module: `adc_serial_ctrl`

## Requirements
- R1: After reset, and before any frame, sdata_oe, conv_active, frame_invalid and quiet_err are 0, powered_up is 1, and sdata_out is 0.
- R2: When the quiet interval has elapsed, a falling edge on cs_n_in starts a frame. conv_active and sdata_oe go to 1, and the word on conv_word is captured at that moment.
- R3: The frame is FRAME_LEN = RES_BITS + 4 bits long (16 for RES_BITS=12, 14 for RES_BITS=10), and bits are numbered 0 to FRAME_LEN-1. Bit 0 appears when the frame starts. Bit k appears after the k-th sclk_in falling edge. Bits 0 to 3 are 0, and bit 4+j carries conv_word[RES_BITS-1-j]. Whenever sdata_oe is 0, sdata_out is 0.
- R4: The FRAME_LEN-th sclk_in falling edge completes the frame. conv_active and sdata_oe drop to 0 while cs_n_in is still low, and the converter is left powered up.
- R5: If cs_n_in rises after 10 to FRAME_LEN-1 falling edges, the frame is abandoned, sdata_oe drops to 0, and powered_up becomes 1. This wakes the converter if it was powered down.
- R6: If cs_n_in rises after 2 to 9 falling edges, the frame is abandoned and powered_up becomes 0.
- R7: If cs_n_in rises after 0 or 1 falling edges, the frame is abandoned and powered_up keeps its value.
- R8: frame_invalid is set at the start of a frame that begins while powered_up is 0 and cleared at the start of a frame that begins while it is 1. It holds its value between frame starts.
- R9: Every frame end starts a quiet window of QUIET_CYC system clocks. A cs_n_in falling edge inside that window starts no frame and sets quiet_err, which stays 1 until reset.
- R10: Outside a frame, sclk_in edges have no effect. So does a cs_n_in rise after a completed frame (select held low past completion).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_in | input | 1 | Asynchronous active-low frame select from the host |
| sclk_in | input | 1 | Asynchronous serial clock from the host |
| conv_word | input | RES_BITS | Conversion result to be sent |
| sdata_out | output | 1 | Serial data bit |
| sdata_oe | output | 1 | Drive enable for the serial data pad (0 = high impedance) |
| powered_up | output | 1 | 1 = normal mode, 0 = power-down |
| conv_active | output | 1 | A conversion frame is in progress |
| frame_invalid | output | 1 | The current or last frame woke the converter, so its data is not valid |
| quiet_err | output | 1 | Sticky: a start was requested inside the quiet window |

## Verification
The hardest situations to reach from the ports are the transitions between power modes. One is a frame that starts while powered down and then ends in each release window. The other is a start request that arrives just after a frame completed with select held low. The stimulus draws a random release edge count for each frame across the whole range 0 to FRAME_LEN, so every wake, sleep and no-change path is taken from both power states. A directed sequence holds select low past completion, toggles it back low at once to provoke the quiet-window rejection, and then pulses the serial clock with select high to show that nothing moves.

// File: rtl/adc_ctrl_pkg.sv
// Shared definitions for the serial converter frame controller.
// Assumes: nothing beyond IEEE 1800-2017.
package adc_ctrl_pkg;

    // Frame sequencer states
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,   // waiting for a select fall
        SEQ_FRAME = 2'd1,   // frame in progress, data driven
        SEQ_HOLD  = 2'd2    // frame complete, select still low
    } seq_state_t;

    // Total frame length from its parts
    function automatic int frame_bits(input int lead, input int res, input int trail);
        return lead + res + trail;
    endfunction

endpackage

// File: rtl/adc_ctrl_sync.sv
// Two-or-more-flop synchroniser with edge detection for one host line.
// Assumes: the input is asynchronous to clk and stays at each level for
// at least STAGES+1 clock cycles so that no edge is lost.
module adc_ctrl_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_lvl,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the asynchronous line
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                // Later stages settle the value
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    // Delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= chain[STAGES-1];
    end

    assign sync_lvl = chain[STAGES-1];
    assign rise     = !prev &&  chain[STAGES-1];
    assign fall     =  prev && !chain[STAGES-1];

endmodule

// File: rtl/adc_ctrl_seq.sv
// Frame sequencer. It counts serial clock falls inside a frame, detects
// completion and early release, and runs the quiet-window timer.
// Assumes: edge pulses are single-cycle and synchronous to clk, and a select
// rise wins over a serial clock fall that arrives in the same cycle.
module adc_ctrl_seq
    import adc_ctrl_pkg::*;
#(
    parameter int FRAME_LEN = 16,
    parameter int QUIET_CYC = 20,
    parameter int EW        = $clog2(FRAME_LEN + 1),
    parameter int QW        = $clog2(QUIET_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_fall,
    input  logic          cs_rise,
    input  logic          sclk_fall,
    output logic          start_frame,
    output logic          shift_bit,
    output logic          frame_end,
    output logic [EW-1:0] end_edges,
    output logic          conv_active,
    output logic          quiet_busy,
    output logic          quiet_err
);

    localparam logic [EW-1:0] LAST_EDGE = EW'(FRAME_LEN - 1);
    localparam logic [EW-1:0] FULL_EDGE = EW'(FRAME_LEN);
    localparam logic [QW-1:0] QUIET_LD  = QW'(QUIET_CYC);

    seq_state_t    state;
    logic [EW-1:0] edge_cnt;
    logic [QW-1:0] quiet_cnt;
    logic          in_frame;
    logic          early_rel;
    logic          last_fall;

    assign in_frame   = (state == SEQ_FRAME);
    assign quiet_busy = (quiet_cnt != '0);
    assign early_rel  = in_frame && cs_rise;
    assign last_fall  = in_frame && !cs_rise && sclk_fall && (edge_cnt == LAST_EDGE);

    // Control pulses for the shifter and the power tracker
    always_comb begin
        start_frame = (state == SEQ_IDLE) && cs_fall && !quiet_busy;
        shift_bit   = in_frame && !cs_rise && sclk_fall && (edge_cnt != LAST_EDGE);
        frame_end   = early_rel || last_fall;
        end_edges   = early_rel ? edge_cnt : FULL_EDGE;
    end

    // State and falling-edge counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            edge_cnt <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (start_frame) begin
                        state    <= SEQ_FRAME;
                        edge_cnt <= '0;
                    end
                end
                SEQ_FRAME: begin
                    if (cs_rise) begin
                        state <= SEQ_IDLE;
                    end else if (sclk_fall) begin
                        edge_cnt <= edge_cnt + 1'b1;
                        if (edge_cnt == LAST_EDGE) state <= SEQ_HOLD;
                    end
                end
                SEQ_HOLD: begin
                    if (cs_rise) state <= SEQ_IDLE;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Quiet-window timer, loaded at every frame end
    always_ff @(posedge clk) begin
        if (!rst_n)          quiet_cnt <= '0;
        else if (frame_end)  quiet_cnt <= QUIET_LD;
        else if (quiet_busy) quiet_cnt <= quiet_cnt - 1'b1;
    end

    // Sticky flag for a start request inside the quiet window
    always_ff @(posedge clk) begin
        if (!rst_n)                                        quiet_err <= 1'b0;
        else if ((state == SEQ_IDLE) && cs_fall && quiet_busy) quiet_err <= 1'b1;
    end

    assign conv_active = in_frame;

endmodule

// File: rtl/adc_ctrl_power.sv
// Power-mode tracker. It decodes the falling-edge count at each frame end
// into sleep, wake or no change, and flags frames that start asleep.
// Assumes: start_frame and frame_end are never high in the same cycle.
module adc_ctrl_power #(
    parameter int EW         = 5,
    parameter int KEEP_EDGES = 10,
    parameter int PDN_EDGES  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_frame,
    input  logic          frame_end,
    input  logic [EW-1:0] end_edges,
    output logic          powered_up,
    output logic          frame_invalid
);

    localparam logic [EW-1:0] KEEP_TH = EW'(KEEP_EDGES);
    localparam logic [EW-1:0] PDN_TH  = EW'(PDN_EDGES);

    // Mode decision at the end of each frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            powered_up <= 1'b1;
        end else if (frame_end) begin
            if (end_edges >= KEEP_TH)     powered_up <= 1'b1;
            else if (end_edges >= PDN_TH) powered_up <= 1'b0;
        end
    end

    // Mark a frame that starts while powered down
    always_ff @(posedge clk) begin
        if (!rst_n)           frame_invalid <= 1'b0;
        else if (start_frame) frame_invalid <= !powered_up;
    end

endmodule

// File: rtl/adc_ctrl_shift.sv
// Output shifter. It builds the padded frame word at the start of a frame,
// moves one bit per shift pulse (MSB first) and gates the pad enable.
// Assumes: the control pulses come from adc_ctrl_seq.
module adc_ctrl_shift #(
    parameter int RES_BITS = 12,
    parameter int LEAD     = 4,
    parameter int TRAIL    = 0,
    parameter int FLEN     = LEAD + RES_BITS + TRAIL
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_frame,
    input  logic                shift_bit,
    input  logic                frame_end,
    input  logic [RES_BITS-1:0] conv_word,
    output logic                sdata_out,
    output logic                sdata_oe
);

    logic [FLEN-1:0] frame_q;
    logic [FLEN-1:0] frame_ld;

    // Place the result below the leading zeros and above the padding
    assign frame_ld = FLEN'(conv_word) << TRAIL;

    // Frame register: load, then shift toward the MSB
    always_ff @(posedge clk) begin
        if (!rst_n)           frame_q <= '0;
        else if (start_frame) frame_q <= frame_ld;
        else if (shift_bit)   frame_q <= {frame_q[FLEN-2:0], 1'b0};
    end

    // Pad enable spans exactly the frame
    always_ff @(posedge clk) begin
        if (!rst_n)           sdata_oe <= 1'b0;
        else if (start_frame) sdata_oe <= 1'b1;
        else if (frame_end)   sdata_oe <= 1'b0;
    end

    assign sdata_out = sdata_oe && frame_q[FLEN-1];

endmodule

// File: rtl/adc_serial_ctrl.sv
// Top of the serial converter frame and power-mode controller. It joins the
// synchronisers, the sequencer, the power tracker and the output shifter.
// Assumes: the host holds each cs_n_in and sclk_in level for at least three
// clk cycles, and RES_BITS is 10 or 12.
module adc_serial_ctrl
    import adc_ctrl_pkg::*;
#(
    parameter int RES_BITS   = 12,
    parameter int LEAD_ZEROS = 4,
    parameter int TRAIL_PAD  = 0,
    parameter int QUIET_CYC  = 20,
    parameter int KEEP_EDGES = 10,
    parameter int PDN_EDGES  = 2,
    parameter int SYNC_STG   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n_in,
    input  logic                sclk_in,
    input  logic [RES_BITS-1:0] conv_word,
    output logic                sdata_out,
    output logic                sdata_oe,
    output logic                powered_up,
    output logic                conv_active,
    output logic                frame_invalid,
    output logic                quiet_err
);

    localparam int FRAME_LEN = frame_bits(LEAD_ZEROS, RES_BITS, TRAIL_PAD);
    localparam int EW        = $clog2(FRAME_LEN + 1);

    logic          cs_lvl, cs_rise, cs_fall;
    logic          sclk_lvl, sclk_rise, sclk_fall;
    logic          start_frame, shift_bit, frame_end, quiet_busy;
    logic [EW-1:0] end_edges;

    adc_ctrl_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst_n(rst_n), .async_in(cs_n_in),
        .sync_lvl(cs_lvl), .rise(cs_rise), .fall(cs_fall)
    );

    adc_ctrl_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) u_sclk_sync (
        .clk(clk), .rst_n(rst_n), .async_in(sclk_in),
        .sync_lvl(sclk_lvl), .rise(sclk_rise), .fall(sclk_fall)
    );

    adc_ctrl_seq #(.FRAME_LEN(FRAME_LEN), .QUIET_CYC(QUIET_CYC), .EW(EW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .sclk_fall(sclk_fall),
        .start_frame(start_frame), .shift_bit(shift_bit), .frame_end(frame_end),
        .end_edges(end_edges), .conv_active(conv_active),
        .quiet_busy(quiet_busy), .quiet_err(quiet_err)
    );

    adc_ctrl_power #(.EW(EW), .KEEP_EDGES(KEEP_EDGES), .PDN_EDGES(PDN_EDGES)) u_pwr (
        .clk(clk), .rst_n(rst_n),
        .start_frame(start_frame), .frame_end(frame_end), .end_edges(end_edges),
        .powered_up(powered_up), .frame_invalid(frame_invalid)
    );

    adc_ctrl_shift #(.RES_BITS(RES_BITS), .LEAD(LEAD_ZEROS), .TRAIL(TRAIL_PAD)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .start_frame(start_frame), .shift_bit(shift_bit), .frame_end(frame_end),
        .conv_word(conv_word), .sdata_out(sdata_out), .sdata_oe(sdata_oe)
    );

    // Levels and rising serial clock edges are not needed by the datapath
    logic unused_ok;
    assign unused_ok = &{1'b0, cs_lvl, sclk_lvl, sclk_rise};

endmodule

// File: rtl/adc_serial_ctrl_chk.sv
// Property checker for adc_serial_ctrl, attached with bind.
// Assumes: it sees the top's ports and its quiet_busy net.
module adc_serial_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic sdata_out,
    input logic sdata_oe,
    input logic powered_up,
    input logic conv_active,
    input logic frame_invalid,
    input logic quiet_err,
    input logic quiet_busy
);

    // R2, R4: the pad is driven exactly while a frame is active
    p_oe_tracks_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sdata_oe == conv_active);

    // R3: the line is quiet when not driven
    p_idle_line_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sdata_oe |-> !sdata_out);

    // R3: the first bit of every frame is a leading zero
    p_first_bit_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdata_oe) |-> !sdata_out);

    // R6: power-down happens only as a frame ends
    p_sleep_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(powered_up) |-> ($past(conv_active) && !conv_active));

    // R8: the validity flag changes only at a frame start
    p_invalid_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(conv_active) |-> $stable(frame_invalid));

    // R9: no frame starts inside the quiet window
    p_quiet_respected_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_active) |-> !$past(quiet_busy));

    // R9: the error flag is sticky
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_err |=> quiet_err);

endmodule

bind adc_serial_ctrl adc_serial_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sdata_out(sdata_out), .sdata_oe(sdata_oe),
    .powered_up(powered_up), .conv_active(conv_active),
    .frame_invalid(frame_invalid), .quiet_err(quiet_err), .quiet_busy(quiet_busy)
);

// File: tb/adc_serial_ctrl_test.sv
// Bench for adc_serial_ctrl: directed corners plus random frames
// with random release points, checked against a bench-side model.
module adc_serial_ctrl_test;

    localparam int RES   = 12;
    localparam int FL    = RES + 4;
    localparam int QUIET = 20;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cs_n = 1'b1;
    logic           sclk = 1'b0;
    logic [RES-1:0] word = '0;
    logic           sdata_out, sdata_oe, powered_up, conv_active, frame_invalid, quiet_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit pwr_m  = 1'b1;

    always #2.5 clk = ~clk;

    adc_serial_ctrl #(.RES_BITS(RES), .QUIET_CYC(QUIET)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n), .sclk_in(sclk), .conv_word(word),
        .sdata_out(sdata_out), .sdata_oe(sdata_oe), .powered_up(powered_up),
        .conv_active(conv_active), .frame_invalid(frame_invalid), .quiet_err(quiet_err)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected bit k of the frame for a given word
    function automatic int exp_bit(input logic [RES-1:0] w, input int k);
        if (k < 4 || k >= 4 + RES) return 0;
        return int'(w[RES-1-(k-4)]);
    endfunction

    // Expected power state after a frame ending with n falling edges
    function automatic bit next_pwr(input bit p, input int n);
        if (n >= 10) return 1'b1;
        if (n >= 2)  return 1'b0;
        return p;
    endfunction

    task automatic sclk_pulse();
        sclk = 1'b1; tick(4);
        sclk = 1'b0; tick(6);
    endtask

    // One frame, with cs released after n falls (n == FL: full frame)
    task automatic run_frame(input logic [RES-1:0] w, input int n, input bit hold_low);
        bit inv_exp;
        inv_exp = !pwr_m;
        word = w;
        cs_n = 1'b0; tick(6);
        chk("R2 active at start", int'(conv_active), 1);
        chk("R2 oe at start", int'(sdata_oe), 1);
        chk("R8 invalid flag", int'(frame_invalid), int'(inv_exp));
        chk("R3 bit 0", int'(sdata_out), 0);
        word = ~w;  // R2: capture happened at start
        for (int k = 1; k <= n; k++) begin
            sclk_pulse();
            if (k < FL) chk($sformatf("R3 bit %0d", k), int'(sdata_out), exp_bit(w, k));
            else        chk("R4 complete drops oe", int'(sdata_oe), 0);
        end
        if (n >= FL) begin
            chk("R4 complete drops active", int'(conv_active), 0);
            chk("R4 powered after complete", int'(powered_up), 1);
            pwr_m = 1'b1;
            if (hold_low) return;
        end
        cs_n = 1'b1; tick(6);
        pwr_m = (n >= FL) ? pwr_m : next_pwr(pwr_m, n);
        chk("R5 R6 R7 oe after release", int'(sdata_oe), 0);
        chk(n >= 10 ? "R5 power" : (n >= 2 ? "R6 power" : "R7 power"),
            int'(powered_up), int'(pwr_m));
        chk("R8 invalid held", int'(frame_invalid), int'(inv_exp));
        tick(QUIET + 10);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        tick(4);
        chk("R1 oe reset", int'(sdata_oe), 0);
        chk("R1 active reset", int'(conv_active), 0);
        chk("R1 powered reset", int'(powered_up), 1);
        chk("R1 err reset", int'(quiet_err), 0);
        chk("R1 invalid reset", int'(frame_invalid), 0);
        chk("R1 sdata reset", int'(sdata_out), 0);
        rst_n = 1'b1; tick(3);

        // R10: clocks with select high do nothing
        for (int i = 0; i < 3; i++) sclk_pulse();
        chk("R10 idle sclk oe", int'(sdata_oe), 0);
        chk("R10 idle sclk active", int'(conv_active), 0);

        run_frame(12'hA5C, FL, 1'b0);           // R4 full frame
        run_frame(12'hFFF, 5, 1'b0);            // R6 sleep
        run_frame(12'h3C1, FL, 1'b0);           // R8 wake frame flagged
        run_frame(12'h800, 12, 1'b0);           // R5 late release stays up
        run_frame(12'h001, 1, 1'b0);            // R7 no change
        run_frame(12'h555, 2, 1'b0);            // R6 lowest sleep count
        run_frame(12'h0F0, 0, 1'b0);            // R7 while asleep
        run_frame(12'hAAA, 10, 1'b0);           // R5 lowest wake count
        run_frame(12'h123, 9, 1'b0);            // R6 highest sleep count

        // R9, R10: hold select low past completion, then restart too early
        run_frame(12'h6B2, FL, 1'b1);
        sclk_pulse();
        chk("R10 sclk after complete", int'(sdata_oe), 0);
        cs_n = 1'b1; tick(4);
        chk("R10 cs rise after complete", int'(powered_up), 1);
        cs_n = 1'b0; tick(6);
        chk("R9 early start ignored", int'(conv_active), 0);
        chk("R9 err set", int'(quiet_err), 1);
        sclk_pulse();
        chk("R9 no drive after reject", int'(sdata_oe), 0);
        cs_n = 1'b1; tick(QUIET + 10);
        run_frame(12'h9E7, FL, 1'b0);
        chk("R9 err sticky", int'(quiet_err), 1);

        // Random frames across all release counts
        for (int i = 0; i < 30; i++) begin
            run_frame(RES'($urandom()), int'($urandom_range(0, FL)), 1'b0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule